// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block is a small, fully associative store that sits next to a direct-mapped cache and catches the lines that cache throws out. Each eviction from the cache arrives on the insert port with its line address and data. When the cache misses, it probes the lookup port. The buffer compares every held entry in parallel and reports a hit and the stored data in the same cycle. On a hit the entry leaves the buffer and returns to the cache. The line that the cache evicts to make room takes its place in the same cycle. The two levels therefore never hold the same line at the same time.

Entries are kept in the order they were inserted. When an insert arrives that is not part of a swap and every entry is in use, the oldest entry is pushed out one cycle later on the spill port, towards the slower next level. Because of this, two addresses that fight over one cache set and are accessed in turn stop missing after warm-up. One of them lives in the cache and the other lives here, and the two trade places on every access.

Top module: `victim_buf`

## Requirements
- R1: After reset no entry is valid. `lk_hit` stays 0 for any probe and `spill_valid` is 0 until a displacement happens.
- R2: With `lk_valid` high, `lk_hit` rises in the same cycle exactly when a valid entry holds `lk_addr`, and `lk_data` then carries that entry's data.
- R3: An insert (`ins_valid` high) with no lookup hit, while fewer than `ENTRIES` entries are valid, stores the line and produces no spill.
- R4: An insert with no lookup hit while all `ENTRIES` entries are valid displaces the least recently inserted entry. One cycle after that clock edge, `spill_valid` is 1 and `spill_addr`/`spill_data` carry that entry.
- R5: A lookup hit in the same cycle as an insert removes the hit entry and stores the inserted line as the most recently inserted entry, with no spill, even when the buffer is full.
- R6: A lookup hit with no insert removes the hit entry. A later probe of that address misses, and the freed slot takes a later insert without a spill.
- R7: `spill_valid` is high for exactly one cycle per displacement and is 0 in every other cycle.
- R8: With a one-set direct-mapped cache in front, two conflicting addresses accessed alternately are found every time after the first two accesses, either in the cache or in the buffer.
- R9: With `lk_valid` low, `lk_hit` is 0 even when `lk_addr` matches a held entry, and that entry stays held.
- R10: Removing an entry from the middle keeps the insertion order of the others, so later spills follow the order in which the remaining lines arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Probe request from a cache miss |
| lk_addr | input | ADDR_W | Line address being probed |
| lk_hit | output | 1 | Probe found the line (combinational) |
| lk_data | output | DATA_W | Data of the hit entry |
| ins_valid | input | 1 | Cache eviction is offered |
| ins_addr | input | ADDR_W | Line address of the evicted line |
| ins_data | input | DATA_W | Data of the evicted line |
| spill_valid | output | 1 | A displaced line is sent to the next level |
| spill_addr | output | ADDR_W | Line address of the displaced line |
| spill_data | output | DATA_W | Data of the displaced line |

## Verification
The case that is hardest to reach is a swap while the buffer is full, where the hit entry sits in the middle of the age order. To reach it, the stimulus has to fill every slot first, then probe a non-oldest entry while offering an eviction in the same cycle. Only the spills that follow show whether the order of the other entries survived. The bench builds this on purpose with a directed sequence. A long stretch of mixed traffic then probes held lines at random positions, often while the buffer is full, and compares every cycle against a queue model.

// File: rtl/victim_buf_pkg.sv
package victim_buf_pkg;

  // Position of the lowest set bit of a one-hot (or zero) vector, 0 if none.
  function automatic int unsigned lowest_set(input logic [31:0] vec);
    int unsigned pos;
    pos = 0;
    for (int k = 31; k >= 0; k--) begin
      if (vec[k]) pos = k;
    end
    return pos;
  endfunction

  // Entries valid after removing `drop` and adding `add` to `used`.
  function automatic int unsigned occupancy_after(input int unsigned used,
                                                  input bit drop,
                                                  input bit add);
    return used - (drop ? 1 : 0) + (add ? 1 : 0);
  endfunction

endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int ADDR_W  = 28,
  parameter int ENTRIES = 4
) (
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
  input  logic [ENTRIES-1:0]             held,
  input  logic [ADDR_W-1:0]              key,
  output logic [ENTRIES-1:0]             match_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = held[g] && (tags[g] == key);
  end
endmodule

// File: rtl/vb_store.sv
module vb_store
  import victim_buf_pkg::*;
#(
  parameter int ADDR_W  = 28,
  parameter int DATA_W  = 64,
  parameter int ENTRIES = 4,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CW = $clog2(ENTRIES + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           drop_en,
  input  logic [IW-1:0]                  drop_idx,
  input  logic                           push_en,
  input  logic [ADDR_W-1:0]              push_addr,
  input  logic [DATA_W-1:0]              push_data,
  output logic [ENTRIES-1:0][ADDR_W-1:0] tags,
  output logic [ENTRIES-1:0][DATA_W-1:0] lines,
  output logic [ENTRIES-1:0]             held,
  output logic [CW-1:0]                  used
);
  // Slot 0 is the oldest entry; valid entries occupy slots 0..used-1.
  logic [ENTRIES-1:0][ADDR_W-1:0] tags_n;
  logic [ENTRIES-1:0][DATA_W-1:0] lines_n;
  logic [CW-1:0]                  used_n;
  logic [CW-1:0]                  used_mid;

  always_comb begin
    used_mid = used - CW'(drop_en);
    used_n   = CW'(occupancy_after(int'(used), drop_en, push_en));
    tags_n   = tags;
    lines_n  = lines;
    for (int i = 0; i < ENTRIES; i++) begin
      if (drop_en && (i >= int'(drop_idx)) && (i + 1 < ENTRIES)) begin
        tags_n[i]  = tags[i+1];
        lines_n[i] = lines[i+1];
      end
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (push_en && (i == int'(used_mid))) begin
        tags_n[i]  = push_addr;
        lines_n[i] = push_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used  <= '0;
      tags  <= '0;
      lines <= '0;
    end else begin
      used  <= used_n;
      tags  <= tags_n;
      lines <= lines_n;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_held
    assign held[g] = (CW'(g) < used);
  end

  // R3: the top never pushes into a full store without freeing a slot.
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (used == CW'(ENTRIES) && push_en) |-> drop_en);

  // R3: occupancy never exceeds the entry count.
  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    used <= CW'(ENTRIES));

  // R6: a removal is only requested for a slot that is in use.
  p_drop_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_en |-> held[drop_idx]);
endmodule

// File: rtl/victim_buf.sv
module victim_buf
  import victim_buf_pkg::*;
#(
  parameter int ADDR_W  = 28,
  parameter int DATA_W  = 64,
  parameter int ENTRIES = 4,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CW = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [DATA_W-1:0] ins_data,
  output logic              spill_valid,
  output logic [ADDR_W-1:0] spill_addr,
  output logic [DATA_W-1:0] spill_data
);
  logic [ENTRIES-1:0][ADDR_W-1:0] tags;
  logic [ENTRIES-1:0][DATA_W-1:0] lines;
  logic [ENTRIES-1:0]             held;
  logic [CW-1:0]                  used;
  logic [ENTRIES-1:0]             probe_vec;
  logic [ENTRIES-1:0]             dup_vec;
  logic [IW-1:0]                  hit_idx;

  // Named internal events.
  logic full;
  logic evict_evt;
  logic swap_evt;
  logic take_evt;
  logic drop_en;
  logic [IW-1:0] drop_idx;

  vb_match #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_probe (
    .tags(tags), .held(held), .key(lk_addr), .match_vec(probe_vec)
  );

  vb_match #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_dup (
    .tags(tags), .held(held), .key(ins_addr), .match_vec(dup_vec)
  );

  always_comb begin
    hit_idx   = IW'(lowest_set(32'(probe_vec)));
    lk_hit    = lk_valid && (|probe_vec);
    lk_data   = lines[hit_idx];
    full      = (used == CW'(ENTRIES));
    swap_evt  = lk_hit && ins_valid;
    take_evt  = lk_hit && !ins_valid;
    evict_evt = ins_valid && !lk_hit && full;
    drop_en   = lk_hit || evict_evt;
    drop_idx  = lk_hit ? hit_idx : '0;
  end

  vb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .drop_en(drop_en), .drop_idx(drop_idx),
    .push_en(ins_valid), .push_addr(ins_addr), .push_data(ins_data),
    .tags(tags), .lines(lines), .held(held), .used(used)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spill_valid <= 1'b0;
      spill_addr  <= '0;
      spill_data  <= '0;
    end else begin
      spill_valid <= evict_evt;
      if (evict_evt) begin
        spill_addr <= tags[0];
        spill_data <= lines[0];
      end
    end
  end

  // R2: exclusivity leaves at most one entry matching any probe.
  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_vec));

  // R1: an empty buffer never reports a hit.
  p_empty_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (used == '0) |-> !lk_hit);

  // R8: an offered eviction is never already held here.
  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> !(|dup_vec));

  // R5: a swap leaves the occupancy unchanged and sends nothing down.
  p_swap_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> (used == $past(used)) && !spill_valid);

  // R6: a hit without a replacement frees exactly one slot.
  p_take_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |=> (used == $past(used) - CW'(1)));

  // R4: a displacement shows the former oldest line on the next cycle.
  p_spill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evict_evt |=> spill_valid && (spill_addr == $past(tags[0]))
                  && (spill_data == $past(lines[0])));

  // R7: a spill cycle is never followed by a spill without a new displacement.
  p_spill_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !evict_evt |=> !spill_valid);
endmodule

// File: tb/sim_victim_buf.sv
`timescale 1ns/1ps
module sim_victim_buf;
  localparam int AW = 28;
  localparam int DW = 64;
  localparam int N  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic lk_hit;
  logic [DW-1:0] lk_data;
  logic ins_valid = 1'b0;
  logic [AW-1:0] ins_addr = '0;
  logic [DW-1:0] ins_data = '0;
  logic spill_valid;
  logic [AW-1:0] spill_addr;
  logic [DW-1:0] spill_data;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit saw_hit;
  logic [AW-1:0] fresh = 28'h100;

  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];

  always #2.5 clk = ~clk;

  victim_buf #(.ADDR_W(AW), .DATA_W(DW), .ENTRIES(N)) u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_data(ins_data),
    .spill_valid(spill_valid), .spill_addr(spill_addr), .spill_data(spill_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk_data(input logic [AW-1:0] a);
    return {a, 4'h5, ~a[27:0], 4'ha};
  endfunction

  // One clock of traffic, compared against the queue model.
  task automatic step(input bit lv, input logic [AW-1:0] la,
                      input bit iv, input logic [AW-1:0] ia, input string req);
    int hi;
    bit exp_sv;
    logic [AW-1:0] ea;
    logic [DW-1:0] ed;
    @(negedge clk);
    lk_valid = lv; lk_addr = la;
    ins_valid = iv; ins_addr = ia; ins_data = mk_data(ia);
    #1;
    hi = -1;
    if (lv) for (int k = 0; k < qa.size(); k++) if (qa[k] == la) hi = k;
    saw_hit = (hi >= 0);
    check(lk_hit == (hi >= 0), {req, "/R2"}, "lk_hit", 64'(lk_hit), 64'(hi >= 0));
    if (hi >= 0) check(lk_data == qd[hi], {req, "/R2"}, "lk_data", lk_data, qd[hi]);
    @(posedge clk);
    #1;
    exp_sv = 0; ea = '0; ed = '0;
    if (hi >= 0) begin
      qa.delete(hi); qd.delete(hi);
    end else if (iv && qa.size() == N) begin
      exp_sv = 1; ea = qa.pop_front(); ed = qd.pop_front();
    end
    if (iv) begin qa.push_back(ia); qd.push_back(mk_data(ia)); end
    check(spill_valid == exp_sv, {req, "/R7"}, "spill_valid", 64'(spill_valid), 64'(exp_sv));
    if (exp_sv) begin
      check(spill_addr == ea, {req, "/R4"}, "spill_addr", 64'(spill_addr), 64'(ea));
      check(spill_data == ed, {req, "/R4"}, "spill_data", spill_data, ed);
    end
  endtask

  task automatic idle(input string req);
    step(0, '0, 0, '0, req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pa, pb, cache_line;
    bit cache_ok;
    repeat (3) @(posedge clk);
    // R1: reset state
    @(negedge clk);
    lk_valid = 1; lk_addr = '0;
    #1;
    check(lk_hit == 0, "R1", "lk_hit in reset", 64'(lk_hit), 0);
    check(spill_valid == 0, "R1", "spill_valid in reset", 64'(spill_valid), 0);
    rst_n = 1;
    lk_valid = 0;
    step(1, 28'h100, 0, '0, "R1");
    check(lk_hit == 0, "R1", "probe after reset", 64'(saw_hit), 0);

    // R3: fill without spills
    for (int k = 0; k < N; k++) step(0, '0, 1, 28'h10 + 28'(k), "R3");
    for (int k = 0; k < N; k++) begin
      step(1, 28'h10 + 28'(k), 1, 28'h20 + 28'(k), "R5");
    end
    // Entries now in order 20,21,22,23 after swaps.
    // R9: masked probe leaves entry held
    step(0, 28'h21, 0, '0, "R9");
    step(1, 28'h21, 0, '0, "R9");
    check(saw_hit == 1, "R9", "entry kept after masked probe", 64'(saw_hit), 1);
    // R6: removed entry misses, slot refilled without spill
    step(1, 28'h21, 0, '0, "R6");
    check(saw_hit == 0, "R6", "removed entry misses", 64'(saw_hit), 0);
    step(0, '0, 1, 28'h30, "R6");
    // R4/R10: full inserts spill in remaining order 20,22,23,30
    for (int k = 0; k < N; k++) step(0, '0, 1, 28'h40 + 28'(k), "R10");
    // R5: swap in the middle of a full buffer, then drain order
    step(1, 28'h41, 1, 28'h50, "R5");
    for (int k = 0; k < N; k++) step(0, '0, 1, 28'h60 + 28'(k), "R10");

    // R8: alternating conflict through a one-set cache model
    pa = 28'h7000; pb = 28'h7400;
    cache_ok = 0; cache_line = '0;
    for (int k = 0; k < 20; k++) begin
      logic [AW-1:0] want;
      bit found;
      want = (k % 2 == 0) ? pa : pb;
      if (cache_ok && cache_line == want) begin
        found = 1; idle("R8");
      end else begin
        step(1, want, cache_ok, cache_line, "R8");
        found = saw_hit;
      end
      cache_ok = 1; cache_line = want;
      if (k >= 2) check(found == 1, "R8", "alternating access found", 64'(found), 1);
    end
    // Flush the cache model line back so the model stays exclusive.
    step(0, '0, 1, cache_line, "R8");

    // Mixed traffic
    for (int k = 0; k < 400; k++) begin
      bit lv, iv;
      logic [AW-1:0] la;
      lv = ($urandom % 3) != 0;
      iv = ($urandom % 2) != 0;
      if (qa.size() > 0 && ($urandom % 2) != 0) la = qa[$urandom % qa.size()];
      else la = 28'hF000000 + 28'(k);
      fresh = fresh + 1;
      step(lv, la, iv, fresh, "R5");
    end
    repeat (2) idle("R7");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule